// File: doc/BRIEF.md
# Data-Side Address Translation Buffer with Mixed Page Sizes

The block translates 64-bit virtual data addresses into 34-bit physical addresses through a fully associative set of 32 entries. Each entry holds a virtual page tag, a physical frame number, a two-bit page-size code and two permission bits. A page is 8 KB, 64 KB, 512 KB or 4 MB, and each size is eight times the one before it. On a lookup, every entry is compared at once. The entry's own size code decides how many low address bits pass straight through and how many take part in the compare and are replaced by the frame number.

A requester raises `lk_valid` with an address and a store flag. One clock later the block reports exactly one outcome: hit (with the physical address), miss, address fault or access violation. Software or a walker outside the block loads entries through the fill port, and a round-robin pointer chooses the slot to overwrite. A single invalidate input empties the whole buffer. Misses are only reported; the block never fetches anything itself.

Top module: `dtb_xlate`

## Requirements
- R1: After reset, all four outcome flags and `lk_pa` are 0 and no entry is valid, so the first lookup of a canonical address reports a miss.
- R2: The outcome of a lookup appears on the outputs in the cycle after the edge at which `lk_valid` was sampled high. In a cycle with no lookup, all four flags are 0.
- R3: An address is canonical when bits 63..43 all equal bit 42. A lookup of a non-canonical address raises `lk_fault` alone, with `lk_hit`, `lk_miss` and `lk_acv` low and `lk_pa` 0.
- R4: A canonical lookup that matches no valid entry raises `lk_miss` for one cycle, with `lk_pa` 0. A miss leaves every entry as it was.
- R5: The size code is 0 for 8 KB, 1 for 64 KB, 2 for 512 KB and 3 for 4 MB. An entry with code s matches when virtual bits 42..13+3s equal the same bits of its tag, which holds virtual bits 42..13. Tag bits below 13+3s are ignored.
- R6: On a hit with size code s, `lk_pa` bits 12+3s..0 equal the virtual address bits. Bits 33..13+3s come from the frame number, which holds physical bits 33..13. `lk_pa` is 0 whenever `lk_hit` is low.
- R7: A load (`lk_store`=0) needs the entry's read bit and a store needs its write bit. A lookup that matches an entry lacking the needed bit raises `lk_acv` alone, with `lk_pa` 0.
- R8: Fills go to the slot named by a victim pointer. The pointer starts at entry 0, advances by one only on a fill, and wraps from 31 back to 0, so the 33rd fill after reset overwrites the first.
- R9: When several valid entries match, the lowest-numbered one supplies the frame number and permissions.
- R10: `inv_all` clears every valid bit and returns the victim pointer to 0 in one cycle. It takes precedence over a fill in the same cycle, so that fill is lost.
- R11: A lookup in the same cycle as a fill sees the contents before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_va | input | 64 | Virtual address to translate |
| lk_store | input | 1 | 1 for a store access, 0 for a load access |
| lk_hit | output | 1 | Translation succeeded |
| lk_miss | output | 1 | No valid entry matched |
| lk_fault | output | 1 | Address was not canonical |
| lk_acv | output | 1 | Matching entry forbids this access |
| lk_pa | output | 34 | Physical address; valid on hit, otherwise 0 |
| fill_en | input | 1 | Write an entry at the victim slot |
| fill_vtag | input | 30 | Virtual page tag, virtual bits 42..13 |
| fill_pfn | input | 21 | Frame number, physical bits 33..13 |
| fill_size | input | 2 | Page-size code, 0..3 |
| fill_rd | input | 1 | Read permission of the new entry |
| fill_wr | input | 1 | Write permission of the new entry |
| inv_all | input | 1 | Invalidate every entry and reset the victim pointer |

## Verification
All four outcomes and the physical address come from one register stage, so each is due one clock after the lookup edge. A fill or an invalidate takes effect at its own edge and is first visible to a lookup sampled at the following edge. The bench applies inputs on the falling edge, returns them to idle on the next falling edge, and reads the outputs there, half a period after the edge that registered them. The same-cycle fill case places the lookup and the fill on the same edge, then repeats the lookup one edge later to observe the written entry.

// File: rtl/dtb_pkg.sv
package dtb_pkg;

    localparam int SZ_BITS = 2;

    // page-size codes; each step multiplies the page by eight
    typedef enum logic [SZ_BITS-1:0] {
        PG_8K   = 2'd0,
        PG_64K  = 2'd1,
        PG_512K = 2'd2,
        PG_4M   = 2'd3
    } pgsz_e;

endpackage

// File: rtl/dtb_match.sv
module dtb_match #(
    parameter int TAG_W = 30,
    parameter int STEP  = 3
) (
    input  logic              vld,
    input  logic [TAG_W-1:0]  tag,
    input  dtb_pkg::pgsz_e    size,
    input  logic [TAG_W-1:0]  va_tag,
    output logic              match
);
    logic [TAG_W-1:0] keep;

    always_comb begin
        keep = '1;
        for (int k = 0; k < TAG_W; k++) begin
            if (k < STEP * int'(size)) keep[k] = 1'b0;
        end
    end

    assign match = vld && (((tag ^ va_tag) & keep) == '0);
endmodule

// File: rtl/dtb_pick.sv
module dtb_pick #(
    parameter int N = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     match,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    assign any = |match;
endmodule

// File: rtl/dtb_splice.sv
module dtb_splice #(
    parameter int PFN_W = 21,
    parameter int STEP  = 3
) (
    input  logic [PFN_W-1:0] pfn,
    input  dtb_pkg::pgsz_e   size,
    input  logic [PFN_W-1:0] va_bits,
    output logic [PFN_W-1:0] frame
);
    logic [PFN_W-1:0] pass;

    always_comb begin
        pass = '0;
        for (int k = 0; k < PFN_W; k++) begin
            if (k < STEP * int'(size)) pass[k] = 1'b1;
        end
        frame = (pfn & ~pass) | (va_bits & pass);
    end
endmodule

// File: rtl/dtb_xlate.sv
module dtb_xlate #(
    parameter int NUM_ENT = 32,
    parameter int VA_W    = 64,
    parameter int VA_IMPL = 43,
    parameter int PA_W    = 34,
    parameter int OFF_W   = 13,
    parameter int STEP    = 3,
    localparam int TAG_W  = VA_IMPL - OFF_W,
    localparam int PFN_W  = PA_W - OFF_W,
    localparam int PTR_W  = $clog2(NUM_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic              lk_store,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_fault,
    output logic              lk_acv,
    output logic [PA_W-1:0]   lk_pa,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_vtag,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [1:0]        fill_size,
    input  logic              fill_rd,
    input  logic              fill_wr,
    input  logic              inv_all
);
    import dtb_pkg::*;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [PFN_W-1:0] pfn;
        pgsz_e            size;
        logic             rd;
        logic             wr;
    } entry_t;

    typedef struct packed {
        entry_t [NUM_ENT-1:0] ent;
        logic [PTR_W-1:0]     ptr;
        logic                 hit;
        logic                 miss;
        logic                 fault;
        logic                 acv;
        logic [PA_W-1:0]      pa;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_ENT-1:0] hit_vec;
    logic               any_hit;
    logic [PTR_W-1:0]   win_idx;
    entry_t             win;
    logic [PFN_W-1:0]   frame;
    logic               canon;
    logic               perm_ok;

    // upper bits must replicate the top implemented bit
    assign canon = (&lk_va[VA_W-1:VA_IMPL-1]) | ~(|lk_va[VA_W-1:VA_IMPL-1]);

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
        dtb_match #(.TAG_W(TAG_W), .STEP(STEP)) u_match (
            .vld    (st_q.ent[g].vld),
            .tag    (st_q.ent[g].tag),
            .size   (st_q.ent[g].size),
            .va_tag (lk_va[VA_IMPL-1:OFF_W]),
            .match  (hit_vec[g])
        );
    end

    dtb_pick #(.N(NUM_ENT)) u_pick (
        .match (hit_vec),
        .any   (any_hit),
        .idx   (win_idx)
    );

    assign win     = st_q.ent[win_idx];
    assign perm_ok = lk_store ? win.wr : win.rd;

    dtb_splice #(.PFN_W(PFN_W), .STEP(STEP)) u_splice (
        .pfn     (win.pfn),
        .size    (win.size),
        .va_bits (lk_va[PA_W-1:OFF_W]),
        .frame   (frame)
    );

    always_comb begin
        st_d       = st_q;
        st_d.hit   = 1'b0;
        st_d.miss  = 1'b0;
        st_d.fault = 1'b0;
        st_d.acv   = 1'b0;
        st_d.pa    = '0;

        if (lk_valid) begin
            if (!canon) begin
                st_d.fault = 1'b1;
            end else if (!any_hit) begin
                st_d.miss = 1'b1;
            end else if (!perm_ok) begin
                st_d.acv = 1'b1;
            end else begin
                st_d.hit = 1'b1;
                st_d.pa  = {frame, lk_va[OFF_W-1:0]};
            end
        end

        if (inv_all) begin
            for (int i = 0; i < NUM_ENT; i++) st_d.ent[i].vld = 1'b0;
            st_d.ptr = '0;
        end else if (fill_en) begin
            st_d.ent[st_q.ptr].vld  = 1'b1;
            st_d.ent[st_q.ptr].tag  = fill_vtag;
            st_d.ent[st_q.ptr].pfn  = fill_pfn;
            st_d.ent[st_q.ptr].size = pgsz_e'(fill_size);
            st_d.ent[st_q.ptr].rd   = fill_rd;
            st_d.ent[st_q.ptr].wr   = fill_wr;
            st_d.ptr = (st_q.ptr == PTR_W'(NUM_ENT - 1)) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lk_hit   = st_q.hit;
    assign lk_miss  = st_q.miss;
    assign lk_fault = st_q.fault;
    assign lk_acv   = st_q.acv;
    assign lk_pa    = st_q.pa;
endmodule

// File: rtl/dtb_xlate_chk.sv
module dtb_xlate_chk #(
    parameter int VA_W    = 64,
    parameter int VA_IMPL = 43,
    parameter int PA_W    = 34,
    parameter int OFF_W   = 13
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    lk_valid,
    input logic [VA_W-VA_IMPL:0]   va_hi,
    input logic [OFF_W-1:0]        va_lo,
    input logic                    lk_hit,
    input logic                    lk_miss,
    input logic                    lk_fault,
    input logic                    lk_acv,
    input logic [PA_W-1:0]         lk_pa
);
    logic in_canon;
    assign in_canon = (&va_hi) | ~(|va_hi);

    assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_hit, lk_miss, lk_fault, lk_acv}));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !(lk_hit || lk_miss || lk_fault || lk_acv));

    assert_noncanon_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !in_canon) |=> (lk_fault && lk_pa == '0));

    assert_canon_answer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && in_canon) |=> $countones({lk_hit, lk_miss, lk_acv}) == 1);

    assert_offset_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && in_canon) |=> (!lk_hit || lk_pa[OFF_W-1:0] == $past(va_lo)));

    assert_pa_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> lk_pa == '0);
endmodule

bind dtb_xlate dtb_xlate_chk #(
    .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PA_W(PA_W), .OFF_W(OFF_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .va_hi    (lk_va[VA_W-1:VA_IMPL-1]),
    .va_lo    (lk_va[OFF_W-1:0]),
    .lk_hit   (lk_hit),
    .lk_miss  (lk_miss),
    .lk_fault (lk_fault),
    .lk_acv   (lk_acv),
    .lk_pa    (lk_pa)
);

// File: tb/dtb_xlate_test.sv
`timescale 1ns/1ps
module dtb_xlate_test;
    localparam logic [3:0] O_NONE = 4'b0000, O_HIT = 4'b1000, O_MISS = 4'b0100,
                           O_FAULT = 4'b0010, O_ACV = 4'b0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [63:0] lk_va = '0;
    logic        lk_store = 1'b0;
    logic        lk_hit, lk_miss, lk_fault, lk_acv;
    logic [33:0] lk_pa;
    logic        fill_en = 1'b0;
    logic [29:0] fill_vtag = '0;
    logic [20:0] fill_pfn = '0;
    logic [1:0]  fill_size = '0;
    logic        fill_rd = 1'b0;
    logic        fill_wr = 1'b0;
    logic        inv_all = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dtb_xlate uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va),
        .lk_store(lk_store), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_fault(lk_fault), .lk_acv(lk_acv), .lk_pa(lk_pa),
        .fill_en(fill_en), .fill_vtag(fill_vtag), .fill_pfn(fill_pfn),
        .fill_size(fill_size), .fill_rd(fill_rd), .fill_wr(fill_wr),
        .inv_all(inv_all)
    );

    function automatic logic [63:0] mk_va(logic [29:0] tag, logic [12:0] off);
        return {{21{tag[29]}}, tag, off};
    endfunction

    function automatic logic [33:0] exp_pa(logic [63:0] va, logic [20:0] pfn, int sz);
        logic [33:0] m;
        m = 34'((64'd1 << (13 + 3 * sz)) - 64'd1);
        return ({pfn, 13'd0} & ~m) | (va[33:0] & m);
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic look_chk(logic [63:0] va, logic st, logic [3:0] exp_o,
                            logic [33:0] epa, string req);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = va; lk_store = st;
        @(negedge clk);
        lk_valid = 1'b0;
        check({req, " outcome"}, 64'({lk_hit, lk_miss, lk_fault, lk_acv}), 64'(exp_o));
        check({req, " pa"}, 64'(lk_pa), 64'(epa));
    endtask

    task automatic fill(logic [29:0] tag, logic [20:0] pfn, logic [1:0] sz,
                        logic rd, logic wr, logic inv);
        @(negedge clk);
        fill_en = 1'b1; fill_vtag = tag; fill_pfn = pfn; fill_size = sz;
        fill_rd = rd; fill_wr = wr; inv_all = inv;
        @(negedge clk);
        fill_en = 1'b0; inv_all = 1'b0;
    endtask

    task automatic invalidate();
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
    endtask

    task automatic fillers(int n, int base);
        for (int i = 0; i < n; i++) fill(30'(base + i), 21'(i), 2'd0, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_reset();
        check("R1 flags after reset", 64'({lk_hit, lk_miss, lk_fault, lk_acv}), 64'(O_NONE));
        check("R1 pa after reset", 64'(lk_pa), 64'd0);
        @(negedge clk);
        check("R2 idle cycle flags", 64'({lk_hit, lk_miss, lk_fault, lk_acv}), 64'(O_NONE));
        look_chk(64'd0, 1'b0, O_MISS, 34'd0, "R1 empty buffer");
    endtask

    task automatic t_sizes();
        logic [63:0] va;
        // entry 0: 8 KB
        fill(30'h0123_4567, 21'h1ABCD, 2'd0, 1'b1, 1'b1, 1'b0);
        va = mk_va(30'h0123_4567, 13'h1F3);
        look_chk(va, 1'b0, O_HIT, exp_pa(va, 21'h1ABCD, 0), "R6 8K hit");
        look_chk(mk_va(30'h0123_4566, 13'h1F3), 1'b0, O_MISS, 34'd0, "R5 8K tag bit0 compared");
        // entry 1: 64 KB, negative canonical address
        fill(30'h2000_0008, 21'h0F0F0, 2'd1, 1'b1, 1'b1, 1'b0);
        va = mk_va(30'h2000_000D, 13'h0A5);
        look_chk(va, 1'b0, O_HIT, exp_pa(va, 21'h0F0F0, 1), "R6 64K hit splice");
        look_chk(mk_va(30'h2000_0000, 13'h0A5), 1'b0, O_MISS, 34'd0, "R5 64K bit above page");
        // entry 2: 4 MB
        fill(30'h0000_4000, 21'h155555, 2'd3, 1'b1, 1'b1, 1'b0);
        va = mk_va(30'h0000_41FF, 13'h1234);
        look_chk(va, 1'b1, O_HIT, exp_pa(va, 21'h155555, 3), "R6 4M hit splice");
        look_chk(mk_va(30'h0000_4200, 13'h0), 1'b0, O_MISS, 34'd0, "R5 4M bit above page");
        // entry 3: 512 KB
        fill(30'h0080_0000, 21'h0AAAAA, 2'd2, 1'b1, 1'b1, 1'b0);
        va = mk_va(30'h0080_003F, 13'h0777);
        look_chk(va, 1'b0, O_HIT, exp_pa(va, 21'h0AAAAA, 2), "R5 512K low tag ignored");
    endtask

    task automatic t_fault();
        look_chk(mk_va(30'h0123_4567, 13'h5) ^ (64'd1 << 63), 1'b0, O_FAULT, 34'd0,
                 "R3 bit63 flipped");
        look_chk(mk_va(30'h0123_4567, 13'h5) ^ (64'd1 << 43), 1'b0, O_FAULT, 34'd0,
                 "R3 bit43 flipped");
    endtask

    task automatic t_perm();
        logic [63:0] va;
        fill(30'h3, 21'h7, 2'd0, 1'b1, 1'b0, 1'b0);  // entry 4: read only
        va = mk_va(30'h3, 13'h10);
        look_chk(va, 1'b1, O_ACV, 34'd0, "R7 store to read-only");
        look_chk(va, 1'b0, O_HIT, exp_pa(va, 21'h7, 0), "R7 load from read-only");
        fill(30'h4, 21'h9, 2'd0, 1'b0, 1'b1, 1'b0);  // entry 5: write only
        va = mk_va(30'h4, 13'h20);
        look_chk(va, 1'b0, O_ACV, 34'd0, "R7 load from write-only");
        look_chk(va, 1'b1, O_HIT, exp_pa(va, 21'h9, 0), "R7 store to write-only");
    endtask

    task automatic t_same_cycle();
        logic [63:0] va;
        va = mk_va(30'h5, 13'h44);
        @(negedge clk);
        fill_en = 1'b1; fill_vtag = 30'h5; fill_pfn = 21'h33; fill_size = 2'd0;
        fill_rd = 1'b1; fill_wr = 1'b1;
        lk_valid = 1'b1; lk_va = va; lk_store = 1'b0;
        @(negedge clk);
        fill_en = 1'b0; lk_valid = 1'b0;
        check("R11 lookup sees old contents",
              64'({lk_hit, lk_miss, lk_fault, lk_acv}), 64'(O_MISS));
        look_chk(va, 1'b0, O_HIT, exp_pa(va, 21'h33, 0), "R11 entry visible after");
    endtask

    task automatic t_round_robin();
        logic [63:0] vh, vk;
        vh = mk_va(30'h0AA000, 13'h1);
        vk = mk_va(30'h0BB000, 13'h2);
        invalidate();
        look_chk(mk_va(30'h0123_4567, 13'h0), 1'b0, O_MISS, 34'd0, "R10 entries cleared");
        fill(30'h0AA000, 21'h100, 2'd0, 1'b1, 1'b1, 1'b0);  // entry 0
        fill(30'h0AA000, 21'h200, 2'd0, 1'b1, 1'b1, 1'b0);  // entry 1
        look_chk(vh, 1'b0, O_HIT, exp_pa(vh, 21'h100, 0), "R9 lowest entry wins");
        fillers(30, 30'h1000);                                 // entries 2..31
        fill(30'h0BB000, 21'h300, 2'd0, 1'b1, 1'b1, 1'b0);  // wraps to entry 0
        look_chk(vh, 1'b0, O_HIT, exp_pa(vh, 21'h200, 0), "R8 33rd fill replaced entry 0");
        look_chk(vk, 1'b0, O_HIT, exp_pa(vk, 21'h300, 0), "R8 wrapped fill present");
        look_chk(mk_va(30'h3FF_FFFF, 13'h0), 1'b0, O_MISS, 34'd0, "R4 miss");
        look_chk(vk, 1'b0, O_HIT, exp_pa(vk, 21'h300, 0), "R4 entries intact after miss");
    endtask

    task automatic t_inv_ptr();
        logic [63:0] vm;
        vm = mk_va(30'h0CC000, 13'h3);
        fillers(30, 30'h2000);  // pointer 1 -> 31
        invalidate();
        fill(30'h0CC000, 21'h411, 2'd0, 1'b1, 1'b1, 1'b0);  // entry 0 if pointer reset
        fill(30'h0CC000, 21'h422, 2'd0, 1'b1, 1'b1, 1'b0);  // entry 1
        look_chk(vm, 1'b0, O_HIT, exp_pa(vm, 21'h411, 0), "R10 pointer back to 0");
        fill(30'h0DD000, 21'h500, 2'd0, 1'b1, 1'b1, 1'b1);  // fill with invalidate
        look_chk(mk_va(30'h0DD000, 13'h0), 1'b0, O_MISS, 34'd0, "R10 invalidate beats fill");
        look_chk(vm, 1'b0, O_MISS, 34'd0, "R10 earlier entries cleared");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sizes();
        t_fault();
        t_perm();
        t_same_cycle();
        t_round_robin();
        t_inv_ptr();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule